// File: doc/BRIEF.md
# Destination-ID Route Lookup

This block is the forwarding-decision stage of one switch port. For each arriving packet header it reads the transport-width code and the format code. It extracts the destination device ID, which is 8 or 16 bits wide depending on that width code. It then looks up a programmable route table and produces a one-cycle result: an output-port bitmask, a flag saying whether the packet is to be replicated, and an error/drop flag. Only the destination ID and the format code steer the decision. Every other header bit passes through uninterpreted.

Each table entry holds a port bitmask and a multicast marker. An entry marked unicast sends the packet to exactly one port. An entry marked multicast sends it to every port in the mask, but only for packet formats that expect no reply: non-acknowledged writes, streaming writes and data-streaming traffic. The table is loaded through a single-cycle configuration write port. It is kept in a synchronous-read memory, so it can map onto a block RAM.

Top module: `dev_route_lookup`

## Requirements
- R1: The header is 22 bits wide. Bits [21:20] carry the width code and bits [19:16] carry the format code. With width code 00 the destination ID is bits [15:8] and indexes the table directly. With width code 01 the destination ID is bits [15:0] and the table is indexed by its low byte, bits [7:0].
- R2: A width code of 10 or 11 produces rt_err=1 with rt_ports=0 and rt_mcast=0.
- R3: A header presented with hdr_valid=1 yields rt_valid=1 on the following cycle, and rt_valid is 0 in any cycle not preceded by hdr_valid=1.
- R4: An entry whose multicast bit (entry bit 8) is 0 and whose mask (entry bits [7:0]) is nonzero forwards to exactly one port: the lowest-numbered set bit of the mask. rt_mcast=0 and rt_err=0.
- R5: An entry with multicast bit 1 and a nonzero mask, hit by format code 5, 6 or 9, drives rt_ports equal to the full mask with rt_mcast=1 and rt_err=0.
- R6: A multicast entry hit by any other format code drives rt_err=1, rt_ports=0 and rt_mcast=0.
- R7: An entry with an all-zero mask drives rt_err=1 and rt_ports=0, whatever its multicast bit.
- R8: A configuration write (cfg_we=1, cfg_addr, cfg_wdata={multicast, mask}) affects lookups presented from the next cycle on. A lookup of the same index in the same cycle as the write sees the previous entry.
- R9: Header bits outside the width code, the format code and the selected destination field have no effect on the result.
- R10: While rt_valid=0, rt_ports, rt_mcast and rt_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_data | input | 22 | Width code, format code and ID field |
| cfg_we | input | 1 | Route table write strobe |
| cfg_addr | input | 8 | Table index to write |
| cfg_wdata | input | 9 | {multicast bit, port mask} |
| rt_valid | output | 1 | Lookup result valid |
| rt_ports | output | 8 | Output-port bitmask |
| rt_mcast | output | 1 | Packet is replicated |
| rt_err | output | 1 | Packet dropped as unroutable |

## Verification
The assertions assume that hdr_valid is held low during reset. They also assume that no header is looked up against a table index that has never been written, because the memory has no reset value. The stimulus loads all 256 entries before the first lookup, and it keeps hdr_valid low throughout reset. It then sweeps every table index in both ID widths, cycling the format code and filling the ignored header bytes with varying values.

// File: rtl/route_pkg.sv
package route_pkg;
  localparam int HDR_W   = 22;
  localparam int TT_MSB  = 21;
  localparam int FT_MSB  = 19;
  localparam int ID_MSB  = 15;

  typedef enum logic [1:0] {
    TT_SMALL = 2'b00,
    TT_LARGE = 2'b01,
    TT_RSV2  = 2'b10,
    TT_RSV3  = 2'b11
  } tt_e;

  function automatic logic fmt_may_replicate(input logic [3:0] ft);
    return (ft == 4'd5) || (ft == 4'd6) || (ft == 4'd9);
  endfunction
endpackage

// File: rtl/rt_hdr_parse.sv
module rt_hdr_parse
  import route_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic [HDR_W-1:0] hdr,
  output logic [IDX_W-1:0] idx,
  output logic             width_bad,
  output logic             rep_ok
);
  tt_e        tt;
  logic [3:0] ft;

  always_comb begin
    tt        = tt_e'(hdr[TT_MSB -: 2]);
    ft        = hdr[FT_MSB -: 4];
    width_bad = (tt == TT_RSV2) || (tt == TT_RSV3);
    rep_ok    = fmt_may_replicate(ft);
    if (tt == TT_LARGE) idx = hdr[IDX_W-1:0];
    else                idx = hdr[ID_MSB -: IDX_W];
  end
endmodule

// File: rtl/rt_table.sv
module rt_table #(
  parameter int IDX_W = 8,
  parameter int ENT_W = 9
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [ENT_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;
  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rt_decide.sv
module rt_decide #(
  parameter int PORTS = 8
) (
  input  logic             valid,
  input  logic             width_bad,
  input  logic             rep_ok,
  input  logic [PORTS:0]   entry,
  output logic [PORTS-1:0] ports,
  output logic             mcast,
  output logic             err
);
  logic [PORTS-1:0] mask;
  logic             is_mc;
  logic [PORTS-1:0] low_bit;

  always_comb begin
    mask    = entry[PORTS-1:0];
    is_mc   = entry[PORTS];
    low_bit = mask & (~mask + 1'b1);
    ports   = '0;
    mcast   = 1'b0;
    err     = 1'b0;
    if (valid) begin
      if (width_bad || mask == '0 || (is_mc && !rep_ok)) begin
        err = 1'b1;
      end else if (is_mc) begin
        ports = mask;
        mcast = 1'b1;
      end else begin
        ports = low_bit;
      end
    end
  end
endmodule

// File: rtl/dev_route_lookup.sv
module dev_route_lookup
  import route_pkg::*;
#(
  parameter int PORTS = 8,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hdr_valid,
  input  logic [HDR_W-1:0] hdr_data,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_addr,
  input  logic [PORTS:0]   cfg_wdata,
  output logic             rt_valid,
  output logic [PORTS-1:0] rt_ports,
  output logic             rt_mcast,
  output logic             rt_err
);
  localparam int ENT_W = PORTS + 1;

  logic [IDX_W-1:0] idx;
  logic             width_bad, rep_ok;
  logic [ENT_W-1:0] entry;
  logic             valid_q, width_bad_q, rep_ok_q;

  rt_hdr_parse #(.IDX_W(IDX_W)) parse_i (
    .hdr(hdr_data), .idx(idx), .width_bad(width_bad), .rep_ok(rep_ok)
  );

  rt_table #(.IDX_W(IDX_W), .ENT_W(ENT_W)) table_i (
    .clk(clk), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .raddr(idx), .rdata(entry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= 1'b0;
      width_bad_q <= 1'b0;
      rep_ok_q    <= 1'b0;
    end else begin
      valid_q     <= hdr_valid;
      width_bad_q <= width_bad;
      rep_ok_q    <= rep_ok;
    end
  end

  rt_decide #(.PORTS(PORTS)) decide_i (
    .valid(valid_q), .width_bad(width_bad_q), .rep_ok(rep_ok_q),
    .entry(entry), .ports(rt_ports), .mcast(rt_mcast), .err(rt_err)
  );

  assign rt_valid = valid_q;
endmodule

// File: rtl/dev_route_lookup_chk.sv
module dev_route_lookup_chk #(
  parameter int PORTS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             hdr_valid,
  input logic [21:0]      hdr_data,
  input logic             rt_valid,
  input logic [PORTS-1:0] rt_ports,
  input logic             rt_mcast,
  input logic             rt_err
);
  assert_valid_follows_R3: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> rt_valid);
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |=> !rt_valid);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !rt_valid |-> (rt_ports == '0 && !rt_mcast && !rt_err));
  assert_drop_no_ports_R7: assert property (@(posedge clk) disable iff (rst)
    rt_err |-> (rt_ports == '0 && !rt_mcast));
  assert_unicast_single_R4: assert property (@(posedge clk) disable iff (rst)
    (rt_valid && !rt_err && !rt_mcast) |-> ($countones(rt_ports) == 1));
  assert_mcast_format_R6: assert property (@(posedge clk) disable iff (rst)
    (rt_valid && rt_mcast) |->
      ($past(hdr_data[19:16]) == 4'd5 || $past(hdr_data[19:16]) == 4'd6 ||
       $past(hdr_data[19:16]) == 4'd9));
  assert_bad_width_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && hdr_data[21]) |=> rt_err);
endmodule

bind dev_route_lookup dev_route_lookup_chk #(.PORTS(PORTS)) chk_i (
  .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_data(hdr_data),
  .rt_valid(rt_valid), .rt_ports(rt_ports), .rt_mcast(rt_mcast), .rt_err(rt_err)
);

// File: tb/dev_route_lookup_tb.sv
module dev_route_lookup_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hdr_valid = 1'b0;
  logic [21:0] hdr_data = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [8:0]  cfg_wdata = '0;
  logic        rt_valid;
  logic [7:0]  rt_ports;
  logic        rt_mcast, rt_err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dev_route_lookup dut_i (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_data(hdr_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rt_valid(rt_valid), .rt_ports(rt_ports), .rt_mcast(rt_mcast), .rt_err(rt_err)
  );

  function automatic logic [8:0] tbl(input int a);
    logic [7:0] m;
    m = 8'((a * 37 + 11) & 8'hFF);
    if (a % 16 == 3) m = 8'h00;
    return {(a % 4 == 1), m};
  endfunction

  function automatic logic [9:0] expect_res(input logic [1:0] tt, input logic [3:0] ft,
                                            input logic [8:0] e);
    logic [7:0] m;
    m = e[7:0];
    if (tt[1] || m == 8'h00) return {1'b1, 1'b0, 8'h00};
    if (e[8]) begin
      if (ft == 4'd5 || ft == 4'd6 || ft == 4'd9) return {1'b0, 1'b1, m};
      return {1'b1, 1'b0, 8'h00};
    end
    for (int b = 0; b < 8; b++)
      if (m[b]) return {1'b0, 1'b0, 8'(1 << b)};
    return {1'b1, 1'b0, 8'h00};
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [8:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input string req, input logic [21:0] h, input logic [9:0] exp);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_data = h;
    @(negedge clk);
    hdr_valid = 1'b0;
    check(req, {rt_valid, rt_err, rt_mcast, rt_ports}, {1'b1, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset", {rt_valid, rt_err, rt_mcast, rt_ports}, 11'h0);
    rst = 1'b0;
    for (int a = 0; a < 256; a++) cfg_write(8'(a), tbl(a));
    @(negedge clk);
    check("R3 idle", {rt_valid, rt_err, rt_mcast, rt_ports}, 11'h0);

    // R1 R4 R5 R6 R7 R9: 8-bit IDs, low byte is ignored noise
    for (int a = 0; a < 256; a++) begin
      logic [3:0] ft;
      ft = 4'((a * 7) % 16);
      lookup("R1_8bit", {2'b00, ft, 8'(a), 8'((a * 13) ^ 8'h5A)},
             expect_res(2'b00, ft, tbl(a)));
    end
    // R1 R9: 16-bit IDs, high byte varies and must not matter
    for (int a = 0; a < 256; a++) begin
      logic [3:0] ft;
      ft = 4'((a * 5 + 3) % 16);
      lookup("R1_16bit", {2'b01, ft, 8'((a * 29) ^ 8'hC3), 8'(a)},
             expect_res(2'b01, ft, tbl(a)));
    end
    // R2: reserved width codes
    lookup("R2 tt10", {2'b10, 4'd5, 8'd4, 8'd4}, 10'h200);
    lookup("R2 tt11", {2'b11, 4'd2, 8'd8, 8'd0}, 10'h200);
    // R5 vs R6 on one multicast entry, every format code
    cfg_write(8'd200, {1'b1, 8'hA5});
    for (int f = 0; f < 16; f++)
      lookup("R5_R6 fmt", {2'b00, 4'(f), 8'd200, 8'd0},
             (f == 5 || f == 6 || f == 9) ? {2'b01, 8'hA5} : 10'h200);
    // R4: lowest set bit chosen
    cfg_write(8'd201, {1'b0, 8'h80});
    lookup("R4 top bit", {2'b00, 4'd2, 8'd201, 8'd0}, {2'b00, 8'h80});
    cfg_write(8'd201, {1'b0, 8'hFF});
    lookup("R4 all bits", {2'b01, 4'd9, 8'h33, 8'd201}, {2'b00, 8'h01});
    // R7: zero mask, multicast marked
    cfg_write(8'd202, {1'b1, 8'h00});
    lookup("R7 zero mc", {2'b00, 4'd5, 8'd202, 8'd0}, 10'h200);
    // R8: write and lookup same index in the same cycle
    cfg_write(8'd10, {1'b0, 8'h04});
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'd10; cfg_wdata = {1'b0, 8'h40};
    hdr_valid = 1'b1; hdr_data = {2'b00, 4'd2, 8'd10, 8'd0};
    @(negedge clk);
    cfg_we = 1'b0; hdr_valid = 1'b0;
    check("R8 old entry", {rt_valid, rt_err, rt_mcast, rt_ports}, {3'b100, 8'h04});
    lookup("R8 new entry", {2'b00, 4'd2, 8'd10, 8'd0}, {2'b00, 8'h40});
    @(negedge clk);
    check("R3 R10 after", {rt_valid, rt_err, rt_mcast, rt_ports}, 11'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule